// File: doc/BRIEF.md
# Serial DAC Command Interface

This block is the digital front end of a two-channel serial DAC. A host sends 24-bit command frames over a three-wire link: a serial clock, a data line, and an active-low frame strobe. The block oversamples all three wires in its own system clock domain and shifts one data bit in on each falling edge of the serial clock while the strobe is low. When the 24th bit has arrived, it decodes the frame and updates a small register file.

For each channel the register file holds a staged input code and a live output code. It also holds a two-bit power-down mode per channel, a per-channel load-mask bit and an internal-reference enable. The live codes and the mode state drive the analog side, which is not part of this block. A frame whose strobe is released early is discarded. A frame on a reserved address changes nothing. After a complete frame, further serial clocks are ignored until the strobe has been raised and lowered again.

Top module: `dac_cmd_if`

## Requirements
- R1: A frame is 24 bits sent MSB first, one bit per falling serial-clock edge while the strobe is low. Bits 23:22 are ignored, bits 21:19 are the command, bits 18:16 are the address and bits 15:0 are the data. The channel code is the DATA_W most significant data bits (data[15 -: DATA_W]).
- R2: A frame acts only on its 24th falling edge counted from the strobe's falling edge. The outputs reflect it within 4 system clocks of that edge. The system clock must be at least 4 times faster than the serial clock.
- R3: If the strobe rises before the 24th falling edge, the partial frame is dropped and no output or stored register changes.
- R4: After the 24th edge, further serial-clock edges while the strobe stays low have no effect. Only a new strobe falling edge starts the next frame.
- R5: Address 000 selects channel A, 001 selects channel B and 111 selects both. For commands 000 to 011, any other address changes no register.
- R6: Command 000 writes the code into the addressed input registers and leaves the output codes unchanged.
- R7: Command 001 copies each addressed input register into its output register.
- R8: Command 010 writes the code into the addressed input registers and then loads every channel's output from its input register, including the new value.
- R9: Command 011 writes the code into both the input and the output register of each addressed channel.
- R10: Command 100 ignores the address. Data bit 0 selects channel A and data bit 1 selects channel B. Each selected channel takes data[5:4] as its power-down mode; the others keep theirs. pd_mode_o[1:0] is channel A and pd_mode_o[3:2] is channel B.
- R11: Command 110 sets ldac_mask_o to data[1:0] (bit 0 is channel A). Command 111 sets ref_en_o to data[0]. Both ignore the address.
- R12: Command 101, and an active rst_ni, clear all input and output codes, power-down modes and mask bits, and turn the reference off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, idles high, data taken on falling edge |
| frame_n_i | input | 1 | Active-low frame strobe |
| sdi_i | input | 1 | Serial data in |
| code_a_o | output | DATA_W | Channel A output code |
| code_b_o | output | DATA_W | Channel B output code |
| pd_mode_o | output | 4 | Power-down modes, A in [1:0], B in [3:2] |
| ldac_mask_o | output | 2 | Load mask per channel, A in bit 0 |
| ref_en_o | output | 1 | Internal reference enable |

## Verification
The assertions check the following on every cycle: register state stays frozen unless a complete-frame pulse occurs, which covers both aborted frames and ignored extra edges. The complete-frame pulse never lasts two cycles. The reset command clears all state, reserved addresses leave the codes untouched, and only the reference command or the reset command can move the reference enable. Bit ordering, field extraction, the exact 24-edge count, and the meaning of each command's effect on the values can only be shown by the bench's scenarios. These scenarios compare the outputs after directed and random frames, including truncated ones and frames with trailing clocks, against a bench model.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  localparam int FRAME_W  = 24;
  localparam int KEEP_W   = 22;  // frame bits below the two ignored MSBs
  localparam int DATA_MAX = 16;
  localparam int NUM_CH   = 2;

  typedef enum logic [2:0] {
    CMD_WR_IN   = 3'b000,
    CMD_UPD     = 3'b001,
    CMD_WR_LOAD = 3'b010,
    CMD_WR_UPD  = 3'b011,
    CMD_PWR     = 3'b100,
    CMD_RESET   = 3'b101,
    CMD_LDAC    = 3'b110,
    CMD_REF     = 3'b111
  } cmd_e;

  typedef struct packed {
    cmd_e                cmd;
    logic [2:0]          addr;
    logic [DATA_MAX-1:0] data;
  } cmd_word_t;

  function automatic logic [NUM_CH-1:0] addr_sel(input logic [2:0] addr);
    case (addr)
      3'b000:  addr_sel = 2'b01;
      3'b001:  addr_sel = 2'b10;
      3'b111:  addr_sel = 2'b11;
      default: addr_sel = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/dac_cmd_sync.sv
module dac_cmd_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/dac_cmd_shift.sv
module dac_cmd_shift
  import dac_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              frame_n_i,
  input  logic              sdi_i,
  output logic              word_vld_o,
  output logic [KEEP_W-1:0] word_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam int SR_W  = KEEP_W - 1;  // ignored MSBs simply fall off the top

  logic             sclk_d, frame_n_d;
  logic             sclk_fall, frame_fall;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic [SR_W-1:0]  sr;

  assign sclk_fall  = sclk_d & ~sclk_i;
  assign frame_fall = frame_n_d & ~frame_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d    <= 1'b1;
      frame_n_d <= 1'b1;
    end else begin
      sclk_d    <= sclk_i;
      frame_n_d <= frame_n_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed      <= 1'b0;
      cnt        <= '0;
      sr         <= '0;
      word_vld_o <= 1'b0;
      word_o     <= '0;
    end else begin
      word_vld_o <= 1'b0;
      if (frame_fall) begin
        armed <= 1'b1;
        cnt   <= '0;
        sr    <= '0;
      end else if (frame_n_i) begin
        armed <= 1'b0;
        cnt   <= '0;
        sr    <= '0;
      end else if (armed && sclk_fall) begin
        sr <= {sr[SR_W-2:0], sdi_i};
        if (cnt == CNT_W'(FRAME_W - 1)) begin
          word_vld_o <= 1'b1;
          word_o     <= {sr, sdi_i};
          armed      <= 1'b0;
          cnt        <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dac_cmd_regs.sv
module dac_cmd_regs
  import dac_cmd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           vld_i,
  input  cmd_word_t                      word_i,
  output logic [NUM_CH-1:0][DATA_W-1:0]  in_q_o,
  output logic [NUM_CH-1:0][DATA_W-1:0]  out_q_o,
  output logic [NUM_CH-1:0][1:0]         pd_q_o,
  output logic [NUM_CH-1:0]              ldac_q_o,
  output logic                           ref_q_o
);
  logic [NUM_CH-1:0] sel;
  logic [DATA_W-1:0] code;

  assign sel  = addr_sel(word_i.addr);
  assign code = word_i.data[DATA_MAX-1 -: DATA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q_o   <= '0;
      out_q_o  <= '0;
      pd_q_o   <= '0;
      ldac_q_o <= '0;
    end else if (vld_i) begin
      for (int c = 0; c < NUM_CH; c++) begin
        unique case (word_i.cmd)
          CMD_WR_IN:  if (sel[c]) in_q_o[c] <= code;
          CMD_UPD:    if (sel[c]) out_q_o[c] <= in_q_o[c];
          CMD_WR_LOAD: begin
            if (|sel) begin
              if (sel[c]) begin
                in_q_o[c]  <= code;
                out_q_o[c] <= code;
              end else begin
                out_q_o[c] <= in_q_o[c];
              end
            end
          end
          CMD_WR_UPD: begin
            if (sel[c]) begin
              in_q_o[c]  <= code;
              out_q_o[c] <= code;
            end
          end
          CMD_PWR:    if (word_i.data[c]) pd_q_o[c] <= word_i.data[5:4];
          CMD_RESET: begin
            in_q_o[c]   <= '0;
            out_q_o[c]  <= '0;
            pd_q_o[c]   <= '0;
            ldac_q_o[c] <= 1'b0;
          end
          CMD_LDAC:   ldac_q_o[c] <= word_i.data[c];
          CMD_REF:    ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                ref_q_o <= 1'b0;
    else if (vld_i && word_i.cmd == CMD_REF)    ref_q_o <= word_i.data[0];
    else if (vld_i && word_i.cmd == CMD_RESET)  ref_q_o <= 1'b0;
  end
endmodule

// File: rtl/dac_cmd_if.sv
module dac_cmd_if
  import dac_cmd_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              frame_n_i,
  input  logic              sdi_i,
  output logic [DATA_W-1:0] code_a_o,
  output logic [DATA_W-1:0] code_b_o,
  output logic [3:0]        pd_mode_o,
  output logic [1:0]        ldac_mask_o,
  output logic              ref_en_o
);
  logic [2:0]                      pins_s;
  logic                            word_vld;
  logic [KEEP_W-1:0]               word_raw;
  cmd_word_t                       word;
  logic [NUM_CH-1:0][DATA_W-1:0]   in_q, out_q;
  logic [NUM_CH-1:0][1:0]          pd_q;
  logic [NUM_CH-1:0]               ldac_q;
  logic                            ref_q;

  // bit 0 sclk, bit 1 strobe (both idle high), bit 2 data
  dac_cmd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sdi_i, frame_n_i, sclk_i}),
    .q_o    (pins_s)
  );

  dac_cmd_shift u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_i     (pins_s[0]),
    .frame_n_i  (pins_s[1]),
    .sdi_i      (pins_s[2]),
    .word_vld_o (word_vld),
    .word_o     (word_raw)
  );

  assign word = cmd_word_t'(word_raw);

  dac_cmd_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (word_vld),
    .word_i   (word),
    .in_q_o   (in_q),
    .out_q_o  (out_q),
    .pd_q_o   (pd_q),
    .ldac_q_o (ldac_q),
    .ref_q_o  (ref_q)
  );

  assign code_a_o    = out_q[0];
  assign code_b_o    = out_q[1];
  assign pd_mode_o   = pd_q;
  assign ldac_mask_o = ldac_q;
  assign ref_en_o    = ref_q;
endmodule

// File: rtl/dac_cmd_if_chk.sv
module dac_cmd_if_chk #(
  parameter int DATA_W = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  vld_i,
  input logic [2:0]            cmd_i,
  input logic [2:0]            addr_i,
  input logic [1:0][DATA_W-1:0] in_i,
  input logic [1:0][DATA_W-1:0] out_i,
  input logic [3:0]            pd_i,
  input logic [1:0]            ldac_i,
  input logic                  ref_i
);
  logic rsv_addr;
  assign rsv_addr = (addr_i != 3'b000) && (addr_i != 3'b001) && (addr_i != 3'b111);

  AST_FROZEN_WITHOUT_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(out_i) && $stable(in_i) && $stable(pd_i) && $stable(ldac_i) && $stable(ref_i)); // R3

  AST_FRAME_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> !vld_i); // R4

  AST_RESERVED_ADDR_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && !cmd_i[2] && rsv_addr |=> $stable(out_i) && $stable(in_i)); // R5

  AST_UPDATE_BOTH_COPIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && cmd_i == 3'b001 && addr_i == 3'b111 |=> out_i == $past(in_i)); // R7

  AST_REF_ONLY_BY_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && cmd_i != 3'b111 && cmd_i != 3'b101 |=> $stable(ref_i)); // R11

  AST_RESET_CMD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && cmd_i == 3'b101 |=> out_i == '0 && in_i == '0 && pd_i == '0 && ldac_i == '0 && !ref_i); // R12
endmodule

bind dac_cmd_if dac_cmd_if_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .vld_i  (word_vld),
  .cmd_i  (word.cmd),
  .addr_i (word.addr),
  .in_i   (in_q),
  .out_i  (out_q),
  .pd_i   (pd_q),
  .ldac_i (ldac_q),
  .ref_i  (ref_q)
);

// File: tb/dac_cmd_if_test.sv
module dac_cmd_if_test;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 16;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              sclk = 1'b1, frame_n = 1'b1, sdi = 1'b0;
  logic [DATA_W-1:0] code_a, code_b;
  logic [3:0]        pd_mode;
  logic [1:0]        ldac_mask;
  logic              ref_en;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [15:0] m_in [2];
  logic [15:0] m_out[2];
  logic [1:0]  m_pd [2];
  logic [1:0]  m_ldac;
  logic        m_ref;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_cmd_if #(.DATA_W(DATA_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .frame_n_i(frame_n), .sdi_i(sdi),
    .code_a_o(code_a), .code_b_o(code_b), .pd_mode_o(pd_mode),
    .ldac_mask_o(ldac_mask), .ref_en_o(ref_en)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_clear();
    for (int c = 0; c < 2; c++) begin
      m_in[c] = '0; m_out[c] = '0; m_pd[c] = '0;
    end
    m_ldac = '0; m_ref = 1'b0;
  endtask

  function automatic logic [1:0] sel_of(input logic [2:0] a);
    case (a)
      3'b000:  return 2'b01;
      3'b001:  return 2'b10;
      3'b111:  return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  function automatic string req_of(input logic [23:0] f);
    logic [1:0] s;
    s = sel_of(f[18:16]);
    if (!f[21] && s == 2'b00) return "R5";
    case (f[21:19])
      3'd0: return "R6";
      3'd1: return "R7";
      3'd2: return "R8";
      3'd3: return "R9";
      3'd4: return "R10";
      3'd5: return "R12";
      default: return "R11";
    endcase
  endfunction

  task automatic model(input logic [23:0] f);
    logic [2:0]  cmd;
    logic [1:0]  s;
    logic [15:0] d;
    cmd = f[21:19]; s = sel_of(f[18:16]); d = f[15:0];
    case (cmd)
      3'd0: for (int c = 0; c < 2; c++) if (s[c]) m_in[c] = d;
      3'd1: for (int c = 0; c < 2; c++) if (s[c]) m_out[c] = m_in[c];
      3'd2: if (s != 2'b00) begin
              for (int c = 0; c < 2; c++) if (s[c]) m_in[c] = d;
              for (int c = 0; c < 2; c++) m_out[c] = m_in[c];
            end
      3'd3: for (int c = 0; c < 2; c++) if (s[c]) begin m_in[c] = d; m_out[c] = d; end
      3'd4: for (int c = 0; c < 2; c++) if (d[c]) m_pd[c] = d[5:4];
      3'd5: model_clear();
      3'd6: m_ldac = d[1:0];
      default: m_ref = d[0];
    endcase
  endtask

  task automatic send(input logic [23:0] f, input int nbits, input int extra);
    frame_n = 1'b0;
    tick(4);
    for (int i = 0; i < nbits; i++) begin
      sdi = f[23-i]; tick(2); sclk = 1'b0; tick(4); sclk = 1'b1; tick(2);
    end
    for (int i = 0; i < extra; i++) begin
      sdi = 1'($urandom); tick(2); sclk = 1'b0; tick(4); sclk = 1'b1; tick(2);
    end
    tick(2);
    frame_n = 1'b1;
    tick(6);
    if (nbits == 24) model(f);
  endtask

  task automatic check(input string req);
    logic [40:0] act, exp;
    act = {code_a, code_b, pd_mode, ldac_mask, ref_en};
    exp = {m_out[0], m_out[1], m_pd[1], m_pd[0], m_ldac, m_ref};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic logic [23:0] mk(input logic [1:0] dc, input logic [2:0] cmd,
                                     input logic [2:0] addr, input logic [15:0] d);
    return {dc, cmd, addr, d};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    model_clear();
    tick(3);
    check("R12");                                   // state under reset
    rst_ni = 1'b1;
    tick(4);
    check("R12");

    send(mk(2'b00, 3'd0, 3'd0, 16'h1234), 24, 0); check("R6");
    send(mk(2'b00, 3'd1, 3'd0, 16'h0000), 24, 0); check("R7");
    send(mk(2'b11, 3'd3, 3'd1, 16'hBEEF), 24, 0); check("R9");
    send(mk(2'b10, 3'd3, 3'd0, 16'h8001), 24, 0); check("R1");   // MSB/LSB placement
    send(mk(2'b00, 3'd3, 3'd0, 16'hFFFF), 23, 0); check("R3");   // one edge short
    send(mk(2'b00, 3'd3, 3'd7, 16'h0F0F), 1, 0);  check("R3");
    send(mk(2'b00, 3'd3, 3'd1, 16'h7777), 0, 0);  check("R2");   // strobe only
    send(mk(2'b00, 3'd0, 3'd7, 16'h5555), 24, 0); check("R6");
    send(mk(2'b00, 3'd2, 3'd0, 16'hAAAA), 24, 0); check("R8");
    send(mk(2'b00, 3'd3, 3'd2, 16'h1111), 24, 0); check("R5");
    send(mk(2'b00, 3'd0, 3'd3, 16'h2222), 24, 0); check("R5");
    send(mk(2'b00, 3'd2, 3'd3, 16'h3333), 24, 0); check("R5");
    send(mk(2'b00, 3'd1, 3'd7, 16'h0000), 24, 0); check("R7");
    send(mk(2'b00, 3'd3, 3'd0, 16'h0F0F), 24, 9); check("R4");   // trailing edges
    send(mk(2'b00, 3'd3, 3'd1, 16'hC3C3), 24, 0); check("R4");
    send(mk(2'b00, 3'd4, 3'd2, 16'h0021), 24, 0); check("R10");
    send(mk(2'b00, 3'd4, 3'd0, 16'h0012), 24, 0); check("R10");
    send(mk(2'b00, 3'd6, 3'd5, 16'h0002), 24, 0); check("R11");
    send(mk(2'b00, 3'd7, 3'd4, 16'h0001), 24, 0); check("R11");
    send(mk(2'b01, 3'd5, 3'd0, 16'hFFFF), 24, 0); check("R12");

    for (int k = 0; k < 160; k++) begin
      logic [23:0] f;
      int nb, ex;
      f  = 24'($urandom);
      if ($urandom_range(0, 3) == 0) f[21:19] = 3'd5 + 3'($urandom_range(0, 2)) * 0;
      if (f[21:19] == 3'd5 && $urandom_range(0, 3) != 0) f[21:19] = 3'd3;
      nb = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 23) : 24;
      ex = (nb == 24) ? $urandom_range(0, 3) : 0;
      send(f, nb, ex);
      check(nb < 24 ? "R3" : req_of(f));
    end

    send(mk(2'b00, 3'd3, 3'd7, 16'h6543), 24, 0);
    send(mk(2'b00, 3'd7, 3'd0, 16'h0001), 24, 0); check("R11");
    rst_ni = 1'b0; model_clear(); tick(2); check("R12");
    rst_ni = 1'b1; tick(4);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R2: watchdog expired, actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule